// File: doc/BRIEF.md
# Wake-up source power controller

This block manages entry into two low-power modes, a deep "sleep" and a lighter "suspend", and gets the core out of them again. The core talks to it through a single 8-bit register. A write sets the mode request bits, the clear-all bit and the wake-source enable bits. A read returns the latched wake flags. The same low bit positions therefore act as enables on a write and as event flags on a read.

Five event inputs feed the block: a glitch detector on the reset pin, an oscillator-failure detector, a timer alarm, a port-match detector and a comparator output. Each input passes through a synchronizer. The comparator only counts on a rising edge; the other inputs count while they are high. An enabled source that fires during a low-power mode latches its flag, drops the active mode request and gives the core a one-cycle wake pulse. A mode request is refused while any flag is still pending. The refusal is silent and leaves the block in run mode.

Top module: `wakePowerCtl`

## Requirements
- R1: While `rstN` is low (synchronous reset), the flags load `rstCause` (bit 4 reset-pin glitch, bit 3 oscillator fail, bit 2 alarm, bit 1 port match, bit 0 comparator), all enables clear, and the block is in run mode with `sleepReq`, `suspendReq` and `wakePulse` low.
- R2: A write with bit 7 set requests sleep, and a write with bit 6 set requests suspend. If both bits are set, sleep wins. An accepted request shows on `sleepReq` or `suspendReq` from the clock edge that takes the write, and the two outputs are never high together.
- R3: A mode request is refused while any flag is 1. The block then stays in run mode, or in its current mode, with no request output changing.
- R4: A write with bit 5 set clears every flag. When the same write also carries bit 7 or bit 6, the clear applies first, so the request can be accepted on that write.
- R5: `rdData` is `{3'b000, flags[4:0]}`, with the bit order of R1. Bits 7 to 5 always read 0.
- R6: Every write loads write bits 3 to 0 as the enables for flag bits 3 to 0. A flag bit 3..0 sets only when its enable is 1 and the block is in sleep or suspend. Otherwise its event changes neither the flags nor the mode.
- R7: The comparator source (bit 0) reacts to a rising edge of its synchronized input only. A level that is already high when the mode is entered does not set the flag.
- R8: The reset-pin glitch flag (bit 4) sets on a glitch in any mode and needs no enable. Write bit 4 has no effect.
- R9: When a flag sets during a low-power mode, the request output drops on that same edge and `wakePulse` is high for exactly one cycle. An input that goes high before clock edge k sets its flag on edge k+2.
- R10: Flags are sticky. A set flag stays set until a clear write or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| rstCause | input | 5 | Flag values loaded during reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data (latched flags) |
| evtIn | input | 5 | Raw event inputs: glitch, osc fail, alarm, port match, comparator |
| sleepReq | output | 1 | Sleep mode active |
| suspendReq | output | 1 | Suspend mode active |
| wakePulse | output | 1 | One-cycle wake indication |

## Verification
A corrupted flag register shows up on `rdData` at once. Because flag and mode state are coupled, it also shows up either as a mode request that is refused when it should be accepted, or as a mode that fails to end with a wake pulse two edges after the synchronized event. A wrong enable or mode state appears within three cycles of an event as a missing or spurious flag, request drop or wake pulse. The bench sweeps every enable pattern, both low-power modes and all five sources, so any single stuck enable bit or wrong mode decode is caught inside that window.

// File: rtl/wakePowerCtl_pkg.sv
package wakePowerCtl_pkg;
  localparam int REG_W      = 8;
  localparam int NUM_EN     = 4;
  localparam int FLAG_W     = NUM_EN + 1;
  localparam int BIT_SLEEP  = 7;
  localparam int BIT_SUSP   = 6;
  localparam int BIT_CLEAR  = 5;

  typedef enum logic [1:0] {
    MODE_RUN     = 2'd0,
    MODE_SLEEP   = 2'd1,
    MODE_SUSPEND = 2'd2
  } modeT;

  typedef struct packed {
    logic clearAll;
    logic loadEn;
  } strobeT;
endpackage

// File: rtl/wakePowerCtl_dp.sv
module wakePowerCtl_dp
  import wakePowerCtl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [NUM_EN-1:0] enBits,
  input  logic              lowActive,
  input  logic [FLAG_W-1:0] evtIn,
  input  logic [FLAG_W-1:0] rstCause,
  output logic [FLAG_W-1:0] flags,
  output logic              flagsAny,
  output logic              setAny
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [FLAG_W-1:0] syncChain [SYNC_STAGES];
  logic [FLAG_W-1:0] synced;
  logic              cmpPrev;
  logic [NUM_EN-1:0] enables;
  logic [FLAG_W-1:0] seen;
  logic [FLAG_W-1:0] setNow;
  logic [FLAG_W-1:0] baseFlags;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncChain[s] <= '0;
    end else begin
      syncChain[0] <= evtIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncChain[s] <= syncChain[s-1];
    end
  end

  assign synced = syncChain[LAST];

  always_ff @(posedge clk) begin
    if (!rstN) cmpPrev <= 1'b0;
    else       cmpPrev <= synced[0];
  end

  genvar g;
  generate
    for (g = 0; g < FLAG_W; g++) begin : gSrc
      if (g == 0) begin : gEdge
        assign seen[g]   = synced[g] & ~cmpPrev;
        assign setNow[g] = seen[g] & enables[g] & lowActive;
      end else if (g < NUM_EN) begin : gLevel
        assign seen[g]   = synced[g];
        assign setNow[g] = seen[g] & enables[g] & lowActive;
      end else begin : gGlitch
        assign seen[g]   = synced[g];
        assign setNow[g] = seen[g];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)              enables <= '0;
    else if (strobe.loadEn) enables <= enBits;
  end

  assign baseFlags = strobe.clearAll ? '0 : flags;

  always_ff @(posedge clk) begin
    if (!rstN) flags <= rstCause;
    else       flags <= baseFlags | setNow;
  end

  assign flagsAny = |flags;
  assign setAny   = |setNow;
endmodule

// File: rtl/wakePowerCtl_ctl.sv
module wakePowerCtl_ctl
  import wakePowerCtl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             flagsAny,
  input  logic             setAny,
  output strobeT           strobe,
  output modeT             mode,
  output logic             lowActive,
  output logic             wakePulse
);
  logic reqLow;
  logic accept;
  modeT modeNext;

  assign strobe.clearAll = wrEn & wrData[BIT_CLEAR];
  assign strobe.loadEn   = wrEn;
  assign reqLow          = wrEn & (wrData[BIT_SLEEP] | wrData[BIT_SUSP]);
  assign accept          = reqLow & (strobe.clearAll | ~flagsAny) & ~setAny;
  assign lowActive       = (mode != MODE_RUN);

  always_comb begin
    modeNext = mode;
    if (lowActive && setAny)  modeNext = MODE_RUN;
    else if (accept)          modeNext = wrData[BIT_SLEEP] ? MODE_SLEEP : MODE_SUSPEND;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode      <= MODE_RUN;
      wakePulse <= 1'b0;
    end else begin
      mode      <= modeNext;
      wakePulse <= lowActive & setAny;
    end
  end
endmodule

// File: rtl/wakePowerCtl.sv
module wakePowerCtl
  import wakePowerCtl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FLAG_W-1:0] rstCause,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic [FLAG_W-1:0] evtIn,
  output logic              sleepReq,
  output logic              suspendReq,
  output logic              wakePulse
);
  strobeT            strobe;
  modeT              mode;
  logic              lowActive;
  logic              flagsAny;
  logic              setAny;
  logic [FLAG_W-1:0] flags;

  wakePowerCtl_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .flagsAny  (flagsAny),
    .setAny    (setAny),
    .strobe    (strobe),
    .mode      (mode),
    .lowActive (lowActive),
    .wakePulse (wakePulse)
  );

  wakePowerCtl_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .enBits    (wrData[NUM_EN-1:0]),
    .lowActive (lowActive),
    .evtIn     (evtIn),
    .rstCause  (rstCause),
    .flags     (flags),
    .flagsAny  (flagsAny),
    .setAny    (setAny)
  );

  assign rdData     = {{(REG_W-FLAG_W){1'b0}}, flags};
  assign sleepReq   = (mode == MODE_SLEEP);
  assign suspendReq = (mode == MODE_SUSPEND);
endmodule

// File: rtl/wakePowerCtl_chk.sv
module wakePowerCtl_chk
  import wakePowerCtl_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [REG_W-1:0] wrData,
  input logic [REG_W-1:0] rdData,
  input logic             sleepReq,
  input logic             suspendReq,
  input logic             wakePulse
);
  assert_no_dual_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(sleepReq && suspendReq));

  assert_entry_clean_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sleepReq) || $rose(suspendReq)) |-> (rdData == '0));

  assert_entry_needs_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sleepReq) || $rose(suspendReq)) |-> $past(wrEn));

  assert_high_bits_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdData[REG_W-1:FLAG_W] == '0);

  assert_wake_one_cycle_R9: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);

  assert_wake_exits_mode_R9: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> (!sleepReq && !suspendReq));

  assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrData[BIT_CLEAR]) |=> ((rdData & $past(rdData)) == $past(rdData)));
endmodule

bind wakePowerCtl wakePowerCtl_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrData     (wrData),
  .rdData     (rdData),
  .sleepReq   (sleepReq),
  .suspendReq (suspendReq),
  .wakePulse  (wakePulse)
);

// File: tb/wakePowerCtl_bench.sv
module wakePowerCtl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] rstCause = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [4:0] evtIn = '0;
  logic       sleepReq;
  logic       suspendReq;
  logic       wakePulse;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wakePowerCtl u_wakePowerCtl (
    .clk(clk), .rstN(rstN), .rstCause(rstCause), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .evtIn(evtIn), .sleepReq(sleepReq), .suspendReq(suspendReq),
    .wakePulse(wakePulse)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [4:0] cause);
    @(negedge clk);
    rstN = 1'b0;
    rstCause = cause;
    evtIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic doWrite(input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    wrData = '0;
  endtask

  task automatic fireEvt(input int src);
    @(negedge clk);
    evtIn[src] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    evtIn[src] = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1: reset state and loaded cause
    doReset(5'b10101);
    @(negedge clk);
    check("R1 flags", rdData, 8'h15);
    check("R1 sleep", sleepReq, 0);
    check("R1 susp", suspendReq, 0);
    check("R1 wake", wakePulse, 0);
    // R3: refused while flags pending
    doWrite(8'h80);
    check("R3 refused sleep", sleepReq, 0);
    doWrite(8'h40);
    check("R3 refused susp", suspendReq, 0);
    check("R10 still set", rdData, 8'h15);
    // R4, R8: clear plus sleep in one write; bit4 write ignored
    doWrite(8'hB0);
    check("R4 cleared", rdData, 0);
    check("R4 accepted", sleepReq, 1);
    check("R8 bit4 write", rdData[4], 0);

    // R2: both mode bits -> sleep
    doReset(5'b0);
    doWrite(8'hC0);
    check("R2 both sleep", sleepReq, 1);
    check("R2 both susp", suspendReq, 0);
    // R5: write-only bits read zero
    check("R5 readback", rdData, 0);

    // R8: glitch in run mode sets flag without wake
    doReset(5'b0);
    fireEvt(4);
    check("R8 glitch run flag", rdData, 8'h10);
    check("R8 glitch no wake", wakePulse, 0);
    check("R8 still run", sleepReq, 0);
    // R6: enabled source in run mode does not set
    doReset(5'b0);
    doWrite(8'h0F);
    fireEvt(2);
    check("R6 run ignores alarm", rdData, 0);

    // R7: comparator held high before entry does not set
    doReset(5'b0);
    @(negedge clk);
    evtIn[0] = 1'b1;
    idle(4);
    doWrite(8'h81);
    idle(4);
    check("R7 level no flag", rdData, 0);
    check("R7 still asleep", sleepReq, 1);
    evtIn[0] = 1'b0;
    idle(4);
    check("R7 fall no flag", rdData, 0);
    evtIn[0] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 rise flag", rdData, 8'h01);
    check("R7 rise wake", wakePulse, 1);
    evtIn[0] = 1'b0;

    // Sweep: every source, both modes, every enable pattern (R6, R9, R10, R2)
    for (int src = 0; src < 5; src++) begin
      for (int m = 0; m < 2; m++) begin
        for (int en = 0; en < 16; en++) begin
          logic hit;
          logic [7:0] modeBits;
          hit = (src == 4) ? 1'b1 : en[src];
          modeBits = (m == 0) ? 8'h80 : 8'h40;
          doReset(5'b0);
          doWrite(modeBits | 8'(en));
          check("R2 sweep entry sleep", sleepReq, (m == 0) ? 1 : 0);
          check("R2 sweep entry susp", suspendReq, (m == 1) ? 1 : 0);
          fireEvt(src);
          check("R6 sweep flag", rdData, hit ? (1 << src) : 0);
          check("R9 sweep wake", wakePulse, hit ? 1 : 0);
          check("R9 sweep sleep", sleepReq, (!hit && m == 0) ? 1 : 0);
          check("R9 sweep susp", suspendReq, (!hit && m == 1) ? 1 : 0);
          @(negedge clk);
          check("R9 sweep wake once", wakePulse, 0);
          check("R10 sweep sticky", rdData, hit ? (1 << src) : 0);
        end
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule